// File: doc/BRIEF.md
# UART Channel Status and Flag Controller

This block keeps the eight-bit status byte of one UART channel and turns its flags into interrupt requests. It sits between a transmit shifter, a receive deserializer and the CPU register port. It holds a one-deep transmit holding buffer and a one-deep receive buffer. It tracks whether each buffer is full. It latches per-character error flags when a byte arrives and drops them when the CPU reads that byte. It also records a wake event when the receive line goes low during stop mode.

Each flag has its own lifetime. Transmit-complete lasts until its interrupt is acknowledged. The wake flag lasts until software writes it to zero. The error flags last until the buffered character is read. While an unread byte sits in the receive buffer, later frames are dropped and flagged as overrun. A write of one to the soft-reset bit returns every flag and buffer of this channel to its reset state. The bit then clears itself a cycle later.

The asynchronous active-low reset is released through a two-stage synchronizer. Outputs take their reset values as soon as the reset is asserted, and normal operation starts two clock edges after it is released.

Top module: `uart_stat_ctrl`

## Requirements
- R1: After reset, `status` reads 0x80, `chan_srst` is 0, `tx_buf_empty` is 1 and `rx_data_ready` is 0. Status bit positions are fixed: 7 transmit-empty, 6 transmit-complete, 5 receive-complete, 4 wake, 3 soft-reset, 2 overrun, 1 frame error, 0 parity error.
- R2: A `cpu_wr_txd` pulse clears bit 7 at the next edge and stores `cpu_wdata` in `tx_hold_data`. A `tx_load` pulse sets bit 7 at the next edge. When both pulse in the same cycle, the write wins and bit 7 stays 0.
- R3: Bit 6 sets at the edge after a `tx_frame_done` pulse, but only if bit 7 was 1 and no `cpu_wr_txd` occurred in that cycle. A `txc_ack` pulse clears bit 6. If `tx_frame_done` and `txc_ack` arrive in the same cycle, the set wins.
- R4: If `rx_byte_done` arrives while bit 5 is 0, bit 5 sets and `rx_rdata` takes `rx_din` at the next edge. A `cpu_rd_rxd` pulse clears bit 5 at the next edge.
- R5: If `rx_byte_done` arrives while bit 5 is 1 and no read happens in that cycle, the frame is discarded. Bit 2 sets, and `rx_rdata`, bit 1 and bit 0 keep their values. A `cpu_rd_rxd` pulse clears bit 2.
- R6: When a byte enters the receive buffer, bit 1 latches the inverse of `rx_stop_lvl`. A `cpu_rd_rxd` pulse clears bit 1.
- R7: When a byte enters the receive buffer, bit 0 latches `rx_par_err AND par_en`. It stays 0 when `par_en` is 0. A `cpu_rd_rxd` pulse clears bit 0.
- R8: Bit 4 sets at the edge after a cycle with `stop_mode`=1 and `rxd`=0. Only a status write with bit 4 of `stat_wdata` equal to 0 clears it. Writing 1 there has no effect, and a set in the same cycle wins over the clear.
- R9: A status write with bit 3 of `stat_wdata` equal to 1 works in two steps. At the next edge, `chan_srst` goes to 1 and `status` reads 0x88. One edge later, `chan_srst` returns to 0 and `status` reads 0x80. Events in the write cycle and in the pulse cycle are ignored.
- R10: A status write does not change bits 7, 6, 5, 2, 1 and 0.
- R11: Each interrupt output is its flag ANDed with its enable, without a register stage: `irq_udre` uses bit 7, `irq_txc` uses bit 6, `irq_rxc` uses bit 5 and `irq_wake` uses bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_txd | input | 1 | CPU write of the transmit data register |
| cpu_wdata | input | DATA_W | Data written to the transmit holding buffer |
| cpu_rd_rxd | input | 1 | CPU read of the receive data register |
| cpu_wr_stat | input | 1 | CPU write of the status register |
| stat_wdata | input | 8 | Data written to the status register |
| tx_load | input | 1 | Shifter took the holding-buffer byte |
| tx_frame_done | input | 1 | Shifter finished sending a whole frame |
| txc_ack | input | 1 | Transmit-complete interrupt serviced |
| rx_byte_done | input | 1 | Deserializer completed a frame |
| rx_din | input | DATA_W | Byte from the deserializer |
| rx_stop_lvl | input | 1 | Sampled level of the first stop bit |
| rx_par_err | input | 1 | Parity mismatch of the completed frame |
| par_en | input | 1 | Parity checking enabled |
| rxd | input | 1 | Receive line level |
| stop_mode | input | 1 | Chip is in stop mode |
| ie_udre | input | 1 | Transmit-empty interrupt enable |
| ie_txc | input | 1 | Transmit-complete interrupt enable |
| ie_rxc | input | 1 | Receive-complete interrupt enable |
| ie_wake | input | 1 | Wake interrupt enable |
| status | output | 8 | Status byte |
| tx_buf_empty | output | 1 | Holding buffer empty (status bit 7) |
| tx_hold_data | output | DATA_W | Holding-buffer contents for the shifter |
| rx_data_ready | output | 1 | Unread byte present (status bit 5) |
| rx_rdata | output | DATA_W | Receive buffer contents |
| irq_udre | output | 1 | Transmit-empty interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_rxc | output | 1 | Receive-complete interrupt request |
| irq_wake | output | 1 | Wake interrupt request |
| chan_srst | output | 1 | Channel-local soft reset pulse |

## Verification
The assertions check these rules on every cycle:
- A data write always empties bit 7.
- Transmit-complete never rises while the holding buffer is full.
- Overrun never rises without an unread byte.
- A discarded frame leaves the buffer and the error flags untouched.
- A read clears all receive flags.
- Hardware never drops the wake flag.
- The soft-reset pulse shows 0x88 and then leaves 0x80.

The bench scenarios are needed for the rest:
- the exact values latched into the error bits;
- the ordering when two events meet in one cycle (write against load, frame done against acknowledge, wake set against clear);
- that status writes leave the read-only bits alone;
- the data paths;
- the interrupt gating.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W = 8;
  // Bit positions are fixed because software decodes them.
  localparam int B_UDRE = 7;
  localparam int B_TXC  = 6;
  localparam int B_RXC  = 5;
  localparam int B_WAKE = 4;
  localparam int B_SRST = 3;
  localparam int B_DOR  = 2;
  localparam int B_FE   = 1;
  localparam int B_PE   = 0;
  localparam logic [STAT_W-1:0] STAT_RST = 8'h80;

  typedef struct packed {
    logic dor;
    logic fe;
    logic pe;
  } rx_err_t;
endpackage

// File: rtl/uart_tx_flags.sv
module uart_tx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_load,
  input  logic              frame_done,
  input  logic              txc_ack,
  output logic              udre,
  output logic              txc,
  output logic [DATA_W-1:0] hold_data
);
  logic              udre_q, udre_d;
  logic              txc_q, txc_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    udre_d  = udre_q;
    txc_d   = txc_q;
    hold_d  = wdata;
    hold_en = 1'b0;
    if (wr_txd) begin
      udre_d  = 1'b0;
      hold_en = 1'b1;
    end else if (tx_load) begin
      udre_d = 1'b1;
    end
    if (frame_done && udre_q && !wr_txd) txc_d = 1'b1;
    else if (txc_ack)                    txc_d = 1'b0;
    if (clr) begin
      udre_d  = 1'b1;
      txc_d   = 1'b0;
      hold_d  = '0;
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      udre_q <= 1'b1;
      txc_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      udre_q <= udre_d;
      txc_q  <= txc_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign udre      = udre_q;
  assign txc       = txc_q;
  assign hold_data = hold_q;

  // R2: a data write always leaves the holding buffer full
  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !clr) |=> !udre_q);
  // R3: transmit-complete only rises with an empty holding buffer
  a_r3_txc_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_q) |-> udre_q);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] din,
  input  logic              stop_lvl,
  input  logic              par_err,
  input  logic              par_en,
  input  logic              rd_data,
  output logic              rxc,
  output rx_err_t           err,
  output logic [DATA_W-1:0] rdata
);
  logic              rxc_q, rxc_d;
  rx_err_t           err_q, err_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              buf_en;
  logic              load;

  assign load = byte_done && (!rxc_q || rd_data);

  always_comb begin
    rxc_d  = rxc_q;
    err_d  = err_q;
    buf_d  = din;
    buf_en = 1'b0;
    if (load) begin
      rxc_d     = 1'b1;
      err_d.fe  = !stop_lvl;
      err_d.pe  = par_en && par_err;
      err_d.dor = 1'b0;
      buf_en    = 1'b1;
    end else if (rd_data) begin
      rxc_d = 1'b0;
      err_d = '0;
    end else if (byte_done) begin
      err_d.dor = 1'b1;
    end
    if (clr) begin
      rxc_d  = 1'b0;
      err_d  = '0;
      buf_d  = '0;
      buf_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_q <= 1'b0;
      err_q <= '0;
      buf_q <= '0;
    end else begin
      rxc_q <= rxc_d;
      err_q <= err_d;
      if (buf_en) buf_q <= buf_d;
    end
  end

  assign rxc   = rxc_q;
  assign err   = err_q;
  assign rdata = buf_q;

  // R5: overrun only rises while an unread byte is held
  a_r5_dor_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q.dor) |-> rxc_q);
  // R5: a discarded frame keeps the buffered byte and its error flags
  a_r5_discard_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rxc_q && byte_done && !rd_data && !clr) |=>
      ($stable(buf_q) && $stable(err_q.fe) && $stable(err_q.pe)));
  // R6: a read with no new frame clears all receive flags
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !byte_done) |=> (!rxc_q && err_q == '0));
endmodule

// File: rtl/uart_wake_flag.sv
module uart_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stop_mode,
  input  logic rxd,
  input  logic sw_clr,
  output logic wake
);
  logic wake_q, wake_d;

  always_comb begin
    wake_d = wake_q;
    if (stop_mode && !rxd) wake_d = 1'b1;
    else if (sw_clr)       wake_d = 1'b0;
    if (clr)               wake_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake = wake_q;

  // R8: hardware never drops the wake flag by itself
  a_r8_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !sw_clr && !clr) |=> wake_q);
endmodule

// File: rtl/uart_stat_ctrl.sv
module uart_stat_ctrl
  import uart_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_txd,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd_rxd,
  input  logic              cpu_wr_stat,
  input  logic [7:0]        stat_wdata,
  input  logic              tx_load,
  input  logic              tx_frame_done,
  input  logic              txc_ack,
  input  logic              rx_byte_done,
  input  logic [DATA_W-1:0] rx_din,
  input  logic              rx_stop_lvl,
  input  logic              rx_par_err,
  input  logic              par_en,
  input  logic              rxd,
  input  logic              stop_mode,
  input  logic              ie_udre,
  input  logic              ie_txc,
  input  logic              ie_rxc,
  input  logic              ie_wake,
  output logic [7:0]        status,
  output logic              tx_buf_empty,
  output logic [DATA_W-1:0] tx_hold_data,
  output logic              rx_data_ready,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              irq_udre,
  output logic              irq_txc,
  output logic              irq_rxc,
  output logic              irq_wake,
  output logic              chan_srst
);
  // Reset: asserted asynchronously, released through two stages.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Soft reset: a single pulse; flags are held clear in the write cycle and the pulse cycle.
  logic soft_req, srst_q, srst_d, clr_all, sw_wake_clr;
  assign soft_req    = cpu_wr_stat && stat_wdata[B_SRST];
  assign srst_d      = soft_req && !srst_q;
  assign clr_all     = soft_req || srst_q;
  assign sw_wake_clr = cpu_wr_stat && !stat_wdata[B_WAKE];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) srst_q <= 1'b0;
    else             srst_q <= srst_d;
  end

  logic    udre, txc, rxc, wake;
  rx_err_t err;

  uart_tx_flags #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr_all),
    .wr_txd(cpu_wr_txd), .wdata(cpu_wdata), .tx_load(tx_load),
    .frame_done(tx_frame_done), .txc_ack(txc_ack),
    .udre(udre), .txc(txc), .hold_data(tx_hold_data)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr_all),
    .byte_done(rx_byte_done), .din(rx_din), .stop_lvl(rx_stop_lvl),
    .par_err(rx_par_err), .par_en(par_en), .rd_data(cpu_rd_rxd),
    .rxc(rxc), .err(err), .rdata(rx_rdata)
  );

  uart_wake_flag u_wake (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr_all),
    .stop_mode(stop_mode), .rxd(rxd), .sw_clr(sw_wake_clr),
    .wake(wake)
  );

  always_comb begin
    status         = '0;
    status[B_UDRE] = udre;
    status[B_TXC]  = txc;
    status[B_RXC]  = rxc;
    status[B_WAKE] = wake;
    status[B_SRST] = srst_q;
    status[B_DOR]  = err.dor;
    status[B_FE]   = err.fe;
    status[B_PE]   = err.pe;
  end

  assign tx_buf_empty  = udre;
  assign rx_data_ready = rxc;
  assign chan_srst     = srst_q;
  assign irq_udre      = udre && ie_udre;
  assign irq_txc       = txc  && ie_txc;
  assign irq_rxc       = rxc  && ie_rxc;
  assign irq_wake      = wake && ie_wake;

  // R9: during the pulse every flag other than transmit-empty is clear
  a_r9_pulse_state: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chan_srst |-> (status == 8'h88));
  // R9: the pulse ends with the reset value
  a_r9_after_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(chan_srst) |-> (status == STAT_RST));
endmodule

// File: tb/tb_uart_stat_ctrl.sv
module tb_uart_stat_ctrl;
  localparam int DW = 8;

  logic clk, rst_n;
  logic cpu_wr_txd, cpu_rd_rxd, cpu_wr_stat;
  logic [DW-1:0] cpu_wdata, rx_din;
  logic [7:0] stat_wdata;
  logic tx_load, tx_frame_done, txc_ack, rx_byte_done, rx_stop_lvl;
  logic rx_par_err, par_en, rxd, stop_mode;
  logic ie_udre, ie_txc, ie_rxc, ie_wake;
  logic [7:0] status;
  logic tx_buf_empty, rx_data_ready, chan_srst;
  logic [DW-1:0] tx_hold_data, rx_rdata;
  logic irq_udre, irq_txc, irq_rxc, irq_wake;

  uart_stat_ctrl #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_txd(cpu_wr_txd), .cpu_wdata(cpu_wdata),
    .cpu_rd_rxd(cpu_rd_rxd), .cpu_wr_stat(cpu_wr_stat), .stat_wdata(stat_wdata),
    .tx_load(tx_load), .tx_frame_done(tx_frame_done), .txc_ack(txc_ack),
    .rx_byte_done(rx_byte_done), .rx_din(rx_din), .rx_stop_lvl(rx_stop_lvl),
    .rx_par_err(rx_par_err), .par_en(par_en), .rxd(rxd), .stop_mode(stop_mode),
    .ie_udre(ie_udre), .ie_txc(ie_txc), .ie_rxc(ie_rxc), .ie_wake(ie_wake),
    .status(status), .tx_buf_empty(tx_buf_empty), .tx_hold_data(tx_hold_data),
    .rx_data_ready(rx_data_ready), .rx_rdata(rx_rdata), .irq_udre(irq_udre),
    .irq_txc(irq_txc), .irq_rxc(irq_rxc), .irq_wake(irq_wake), .chan_srst(chan_srst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Control field of a vector (bits 27:16)
  localparam logic [11:0] WRTX = 12'h800, TXLD = 12'h400, FDON = 12'h200, TACK = 12'h100;
  localparam logic [11:0] BDON = 12'h080, SLOW = 12'h040, PERR = 12'h020, PEN  = 12'h010;
  localparam logic [11:0] RD   = 12'h008, WRST = 12'h004, SMOD = 12'h002, RXLO = 12'h001;

  // {req[31:28], ctl[27:16], data[15:8], expected status[7:0]}
  localparam logic [31:0] VEC [20] = '{
    {4'd2,  WRTX,             8'hA5, 8'h00},  // R2 write fills
    {4'd2,  TXLD,             8'h00, 8'h80},  // R2 load empties
    {4'd3,  FDON,             8'h00, 8'hC0},  // R3 set when empty
    {4'd3,  TACK,             8'h00, 8'h80},  // R3 ack clears
    {4'd4,  BDON|PEN,         8'h3C, 8'hA0},  // R4 byte in
    {4'd5,  BDON|SLOW|PERR|PEN, 8'h55, 8'hA4},// R5 overrun, errors kept
    {4'd5,  RD,               8'h00, 8'h80},  // R5 read clears overrun
    {4'd6,  BDON|SLOW|PERR|PEN, 8'h66, 8'hA3},// R6 frame error, parity error
    {4'd6,  RD,               8'h00, 8'h80},  // R6 read clears
    {4'd7,  BDON|PERR,        8'h77, 8'hA0},  // R7 parity disabled
    {4'd4,  RD,               8'h00, 8'h80},  // R4 read clears
    {4'd8,  SMOD|RXLO,        8'h00, 8'h90},  // R8 wake set
    {4'd10, WRST,             8'hF7, 8'h90},  // R10 write ignored bits, wake 1 no effect
    {4'd8,  RXLO,             8'h00, 8'h90},  // R8 no stop mode, stays
    {4'd8,  WRST,             8'h00, 8'h80},  // R8 software clear
    {4'd8,  SMOD,             8'h00, 8'h80},  // R8 line high, no wake
    {4'd2,  WRTX,             8'h11, 8'h00},
    {4'd3,  FDON,             8'h00, 8'h00},  // R3 no set while full
    {4'd2,  TXLD|WRTX,        8'h22, 8'h00},  // R2 write wins over load
    {4'd2,  TXLD,             8'h00, 8'h80}
  };

  task automatic idle();
    cpu_wr_txd = 0; cpu_rd_rxd = 0; cpu_wr_stat = 0; tx_load = 0;
    tx_frame_done = 0; txc_ack = 0; rx_byte_done = 0; rx_stop_lvl = 1;
    rx_par_err = 0; par_en = 0; rxd = 1; stop_mode = 0;
    cpu_wdata = '0; rx_din = '0; stat_wdata = '0;
  endtask

  task automatic drive(input logic [11:0] c, input logic [7:0] d);
    cpu_wr_txd = c[11]; tx_load = c[10]; tx_frame_done = c[9]; txc_ack = c[8];
    rx_byte_done = c[7]; rx_stop_lvl = !c[6]; rx_par_err = c[5]; par_en = c[4];
    cpu_rd_rxd = c[3]; cpu_wr_stat = c[2]; stop_mode = c[1]; rxd = !c[0];
    cpu_wdata = d; rx_din = d; stat_wdata = d;
  endtask

  // Drive at the falling edge, let one rising edge pass, return to idle and sample.
  task automatic step(input logic [11:0] c, input logic [7:0] d);
    @(negedge clk); drive(c, d);
    @(negedge clk); idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    ie_udre = 0; ie_txc = 0; ie_rxc = 0; ie_wake = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(status == 8'h80, "R1 status", status, 8'h80);
    check(!chan_srst && tx_buf_empty && !rx_data_ready, "R1 handshakes",
          {chan_srst, tx_buf_empty, rx_data_ready}, 3'b010);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(status == 8'h80, "R1 status after release", status, 8'h80);

    for (int i = 0; i < 20; i++) begin
      step(VEC[i][27:16], VEC[i][15:8]);
      check(status == VEC[i][7:0], $sformatf("R%0d vector %0d", VEC[i][31:28], i),
            status, VEC[i][7:0]);
    end
    check(tx_hold_data == 8'h22, "R2 hold data", tx_hold_data, 8'h22);

    // R4 and R5: data path and discard
    step(BDON|PEN, 8'h3C);
    check(rx_rdata == 8'h3C, "R4 rx data", rx_rdata, 8'h3C);
    step(BDON|SLOW, 8'h99);
    check(rx_rdata == 8'h3C, "R5 discarded byte", rx_rdata, 8'h3C);
    check(status == 8'hA4, "R5 flags after discard", status, 8'hA4);
    step(RD, 8'h00);
    check(status == 8'h80, "R5 read clears", status, 8'h80);

    // R3: frame done wins over acknowledge
    step(FDON|TACK, 8'h00);
    check(status == 8'hC0, "R3 set over ack", status, 8'hC0);
    step(TACK, 8'h00);

    // R8: set wins over software clear
    step(SMOD|RXLO|WRST, 8'h00);
    check(status == 8'h90, "R8 set over clear", status, 8'h90);

    // R11: interrupt gating
    ie_udre = 1; ie_wake = 1;
    step(BDON|PEN, 8'h44);
    #1;
    check({irq_udre, irq_txc, irq_rxc, irq_wake} == 4'b1001, "R11 irq partial",
          {irq_udre, irq_txc, irq_rxc, irq_wake}, 4'b1001);
    ie_rxc = 1; ie_udre = 0; #1;
    check({irq_udre, irq_txc, irq_rxc, irq_wake} == 4'b0011, "R11 irq enables",
          {irq_udre, irq_txc, irq_rxc, irq_wake}, 4'b0011);

    // R9: soft reset with several flags set
    step(WRTX, 8'h5A);
    check(status == 8'h30, "R9 before soft reset", status, 8'h30);
    @(negedge clk); drive(WRST, 8'h08);
    @(negedge clk); drive(BDON|FDON|SMOD|RXLO, 8'hEE);
    check(chan_srst && status == 8'h88, "R9 pulse", status, 8'h88);
    @(negedge clk); idle();
    check(!chan_srst && status == 8'h80, "R9 after pulse", status, 8'h80);
    check(rx_rdata == 8'h00 && tx_hold_data == 8'h00, "R9 buffers cleared",
          {rx_rdata, tx_hold_data}, 16'h0000);
    @(negedge clk);
    check(status == 8'h80 && !chan_srst, "R9 settled", status, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule